// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block sits beside a program sequencer and runs counted loops without any branch or decrement instructions in the program. It holds two independent loop units. Each unit stores a start address, an end address and a remaining-repeat count. Software loads these through a small register-write port.

On every cycle the block compares the current program counter with the end address of each unit. From the result it picks the next fetch address: either the next sequential address or a jump back to the start of the loop. When it jumps, the count of the winning unit is decremented at the same clock edge. A loop therefore costs no cycles per iteration.

The count register holds the number of jumps still to take. To run a body N times, load N-1. Unit 1 is treated as the inner loop and is evaluated ahead of unit 0.

Top module: `zol_sequencer`

## Requirements
- R1: After reset every start, end and count register is zero. With no register loaded, `npc_o` is `pc_i`+1 and `loop_taken_o` is 0.
- R2: A register write takes effect on the cycle after `cfg_we_i` is sampled high. It uses `cfg_unit_i` (0 or 1) to pick the unit and `cfg_field_i` to pick the register: 0 is the start address, 1 is the end address and 2 is the count. The fetch decision in the write cycle still uses the old values.
- R3: When `pc_i` equals a unit's end address and that unit's count is non-zero, `npc_o` is that unit's start address and `loop_taken_o` is 1 in the same cycle.
- R4: When `pc_i` equals a unit's end address and its count is zero, that unit does not redirect fetch. The loop exits to `pc_i`+1.
- R5: Each taken jump decrements the winning unit's count by one at the next edge. A count loaded with N-1 makes the body run exactly N times.
- R6: Unit 1 has priority. When both units sit at their end address, unit 1 jumps while its count is non-zero, and unit 0's count is left unchanged. Unit 0 jumps only once unit 1's count is zero. At most one unit decrements per cycle.
- R7: A count of zero never wraps. A loop loaded with 0 runs once, and it falls through again on every later arrival at its end address.
- R8: A count write in the same cycle as a decrement of that unit wins. The written value is what the count holds afterwards.
- R9: When no unit jumps, `npc_o` is `pc_i`+1 modulo 2^ADDR_W, so 0xFFFF is followed by 0x0000.
- R10: A write with `cfg_field_i` = 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | ADDR_W | Address of the instruction being fetched |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_unit_i | input | UNIT_W | Loop unit addressed by the write |
| cfg_field_i | input | 2 | Register addressed: 0 start, 1 end, 2 count, 3 none |
| cfg_data_i | input | DATA_W | Write data |
| npc_o | output | ADDR_W | Next fetch address |
| loop_taken_o | output | 1 | High when fetch is redirected to a loop start |

## Verification
The assertions check several properties on every cycle:
- a count never steps below zero;
- a decrement lowers the count by exactly one;
- a count write beats a decrement;
- at most one unit decrements;
- the inner unit wins when it can jump;
- fetch stays sequential whenever no jump is taken.

Some properties only the bench scenarios can show at the ports:
- the exact number of body passes for a loaded count;
- the one-cycle delay of a register write;
- the hand-over from an exhausted inner loop to the outer loop at a shared end address;
- address wrap;
- the ignored field code.

// File: rtl/zol_pkg.sv
package zol_pkg;

  typedef enum logic [1:0] {
    FLD_START = 2'd0,
    FLD_END   = 2'd1,
    FLD_COUNT = 2'd2,
    FLD_NONE  = 2'd3
  } zol_field_e;

endpackage

// File: rtl/zol_loop_unit.sv
module zol_loop_unit
  import zol_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  zol_field_e        wr_field_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              dec_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] start_o
);

  logic [ADDR_W-1:0] start_q, start_d;
  logic [ADDR_W-1:0] end_q,   end_d;
  logic [CNT_W-1:0]  cnt_q,   cnt_d;
  logic              start_en, end_en, cnt_en;
  logic              cnt_wr;

  // clock enables and next-state values
  always_comb begin
    start_en = wr_en_i && (wr_field_i == FLD_START);
    end_en   = wr_en_i && (wr_field_i == FLD_END);
    cnt_wr   = wr_en_i && (wr_field_i == FLD_COUNT);
    cnt_en   = cnt_wr || dec_i;
    start_d  = wr_data_i[ADDR_W-1:0];
    end_d    = wr_data_i[ADDR_W-1:0];
    if (cnt_wr) begin
      cnt_d = wr_data_i[CNT_W-1:0];
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      cnt_q   <= '0;
    end else begin
      if (start_en) start_q <= start_d;
      if (end_en)   end_q   <= end_d;
      if (cnt_en)   cnt_q   <= cnt_d;
    end
  end

  assign hit_o   = (pc_i == end_q) && (cnt_q != '0);
  assign start_o = start_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> (cnt_q != '0)); // R7
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !cnt_wr) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wr_data_i[CNT_W-1:0]))); // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !dec_i) |=> $stable(cnt_q)); // R10

endmodule

// File: rtl/zol_pick.sv
module zol_pick #(
  parameter int NUM_LOOPS = 2,
  parameter int ADDR_W    = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ADDR_W-1:0]                pc_i,
  input  logic [NUM_LOOPS-1:0]             hit_i,
  input  logic [NUM_LOOPS-1:0][ADDR_W-1:0] start_i,
  output logic [NUM_LOOPS-1:0]             dec_o,
  output logic [ADDR_W-1:0]                npc_o,
  output logic                             taken_o
);

  localparam int SEL_W = (NUM_LOOPS > 1) ? $clog2(NUM_LOOPS) : 1;

  logic [SEL_W-1:0]  sel;
  logic              any;
  logic [ADDR_W-1:0] seq_pc;

  assign seq_pc = pc_i + ADDR_W'(1);

  // highest index is the innermost loop: later iterations override
  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = 0; i < NUM_LOOPS; i++) begin
      if (hit_i[i]) begin
        sel = SEL_W'(i);
        any = 1'b1;
      end
    end
  end

  always_comb begin
    dec_o = '0;
    if (any) dec_o[sel] = 1'b1;
    taken_o = any;
    npc_o   = any ? start_i[sel] : seq_pc;
  end

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dec_o)); // R6
  AST_INNER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i[NUM_LOOPS-1] |-> (dec_o[NUM_LOOPS-1] && taken_o)); // R6
  AST_SEQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i == '0) |-> (!taken_o && npc_o == seq_pc)); // R9

endmodule

// File: rtl/zol_sequencer.sv
module zol_sequencer
  import zol_pkg::*;
#(
  parameter  int NUM_LOOPS = 2,
  parameter  int ADDR_W    = 16,
  parameter  int CNT_W     = 16,
  localparam int UNIT_W    = (NUM_LOOPS > 1) ? $clog2(NUM_LOOPS) : 1,
  localparam int DATA_W    = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              cfg_we_i,
  input  logic [UNIT_W-1:0] cfg_unit_i,
  input  logic [1:0]        cfg_field_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  output logic [ADDR_W-1:0] npc_o,
  output logic              loop_taken_o
);

  logic [NUM_LOOPS-1:0]             hit;
  logic [NUM_LOOPS-1:0]             dec;
  logic [NUM_LOOPS-1:0][ADDR_W-1:0] start_addr;
  zol_field_e                       field;

  assign field = zol_field_e'(cfg_field_i);

  for (genvar u = 0; u < NUM_LOOPS; u++) begin : g_unit
    logic unit_we;
    assign unit_we = cfg_we_i && (cfg_unit_i == UNIT_W'(u));

    zol_loop_unit #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W)
    ) unit_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (unit_we),
      .wr_field_i (field),
      .wr_data_i  (cfg_data_i),
      .pc_i       (pc_i),
      .dec_i      (dec[u]),
      .hit_o      (hit[u]),
      .start_o    (start_addr[u])
    );
  end

  zol_pick #(
    .NUM_LOOPS (NUM_LOOPS),
    .ADDR_W    (ADDR_W)
  ) pick_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .pc_i    (pc_i),
    .hit_i   (hit),
    .start_i (start_addr),
    .dec_o   (dec),
    .npc_o   (npc_o),
    .taken_o (loop_taken_o)
  );

  AST_TAKEN_DECS: assert property (@(posedge clk) disable iff (!rst_n)
    loop_taken_o |-> ($countones(dec) == 1)); // R5

endmodule

// File: tb/zol_sequencer_tb_top.sv
module zol_sequencer_tb_top;

  logic        clk;
  logic        rst_n;
  logic [15:0] pc;
  logic        we;
  logic        unit;
  logic [1:0]  field;
  logic [15:0] data;
  logic [15:0] npc;
  logic        taken;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [15:0] q_npc[$];
  logic        q_tk[$];
  string       q_tag[$];

  zol_sequencer dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pc_i         (pc),
    .cfg_we_i     (we),
    .cfg_unit_i   (unit),
    .cfg_field_i  (field),
    .cfg_data_i   (data),
    .npc_o        (npc),
    .loop_taken_o (taken)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // driver: one cycle of stimulus plus its expected result
  task automatic cyc(input logic w, input logic u, input logic [1:0] f,
                     input logic [15:0] d, input logic [15:0] p,
                     input logic [15:0] e_npc, input logic e_tk, input string tag);
    @(negedge clk);
    we = w; unit = u; field = f; data = d; pc = p;
    q_npc.push_back(e_npc);
    q_tk.push_back(e_tk);
    q_tag.push_back(tag);
  endtask

  task automatic fetch(input logic [15:0] p, input logic [15:0] e_npc,
                       input logic e_tk, input string tag);
    cyc(1'b0, 1'b0, 2'd0, 16'h0, p, e_npc, e_tk, tag);
  endtask

  task automatic wr(input logic u, input logic [1:0] f, input logic [15:0] d);
    cyc(1'b1, u, f, d, 16'h0F00, 16'h0F01, 1'b0, "R2");
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compare just before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q_npc.size() > 0) begin
        logic [15:0] en;
        logic        et;
        string       tg;
        en = q_npc.pop_front();
        et = q_tk.pop_front();
        tg = q_tag.pop_front();
        chk({tg, " npc"}, int'(npc), int'(en));
        chk({tg, " taken"}, int'(taken), int'(et));
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int passes;
    rst_n = 1'b0; we = 1'b0; unit = 1'b0; field = 2'd0; data = '0; pc = '0;
    // R1: reset state seen at the ports
    fetch(16'h0000, 16'h0001, 1'b0, "R1");
    fetch(16'h0005, 16'h0006, 1'b0, "R1");
    @(negedge clk); rst_n = 1'b1;
    fetch(16'h0000, 16'h0001, 1'b0, "R1");

    // R3 R4 R5: three-pass loop on unit 0
    wr(1'b0, 2'd0, 16'h0010);
    wr(1'b0, 2'd1, 16'h0013);
    wr(1'b0, 2'd2, 16'd2);
    passes = 0;
    for (int it = 0; it < 3; it++) begin
      fetch(16'h0010, 16'h0011, 1'b0, "R5");
      fetch(16'h0011, 16'h0012, 1'b0, "R5");
      fetch(16'h0012, 16'h0013, 1'b0, "R5");
      passes++;
      if (it < 2) fetch(16'h0013, 16'h0010, 1'b1, "R3");
      else        fetch(16'h0013, 16'h0014, 1'b0, "R4");
    end
    chk("R5 body passes", passes, 3);

    // R7: zero count, single pass, never wraps
    wr(1'b0, 2'd2, 16'd0);
    fetch(16'h0013, 16'h0014, 1'b0, "R7");
    fetch(16'h0013, 16'h0014, 1'b0, "R7");

    // R10: field code 3 is ignored
    wr(1'b0, 2'd3, 16'h0005);
    fetch(16'h0013, 16'h0014, 1'b0, "R10");
    fetch(16'h0005, 16'h0006, 1'b0, "R10");
    fetch(16'h0010, 16'h0011, 1'b0, "R10");

    // R6: shared end address, inner unit 1 first
    wr(1'b1, 2'd0, 16'h0020);
    wr(1'b1, 2'd1, 16'h0023);
    wr(1'b1, 2'd2, 16'd1);
    wr(1'b0, 2'd0, 16'h0018);
    wr(1'b0, 2'd1, 16'h0023);
    wr(1'b0, 2'd2, 16'd1);
    fetch(16'h0023, 16'h0020, 1'b1, "R6");
    fetch(16'h0023, 16'h0018, 1'b1, "R6");
    fetch(16'h0023, 16'h0024, 1'b0, "R6");

    // R8: count write overrides decrement in the same cycle
    wr(1'b0, 2'd0, 16'h0030);
    wr(1'b0, 2'd1, 16'h0031);
    wr(1'b0, 2'd2, 16'd1);
    cyc(1'b1, 1'b0, 2'd2, 16'd3, 16'h0031, 16'h0030, 1'b1, "R8");
    fetch(16'h0031, 16'h0030, 1'b1, "R8");
    fetch(16'h0031, 16'h0030, 1'b1, "R8");
    fetch(16'h0031, 16'h0030, 1'b1, "R8");
    fetch(16'h0031, 16'h0032, 1'b0, "R8");

    // R2: end address write acts one cycle later
    wr(1'b1, 2'd2, 16'd2);
    wr(1'b1, 2'd0, 16'h003C);
    cyc(1'b1, 1'b1, 2'd1, 16'h0040, 16'h0040, 16'h0041, 1'b0, "R2");
    fetch(16'h0040, 16'h003C, 1'b1, "R2");

    // R9: sequential wrap
    fetch(16'hFFFF, 16'h0000, 1'b0, "R9");
    fetch(16'h1234, 16'h1235, 1'b0, "R9");

    @(negedge clk); we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule